// File: doc/BRIEF.md
# E1 National-Bit Data Link Extractor

This block sits behind the alignment logic of an E1 receiver. It watches the recovered serial stream, a frame marker that flags the first bit of every 256-bit frame, and a multiframe marker that flags frame 0 of each multiframe. From timeslot 0 of each frame that carries no alignment word, it picks the national bits Sa4..Sa8 that a five-bit enable register selects. It then hands the picked bits to an external data link device over a serial data line and a gated strobe.

The picked bits are first held in a small buffer. They are then replayed at half the line rate. Each bit is put on the data line one line clock before its strobe rises, and stays there until the strobe has fallen again. The strobe is therefore bursty: it pulses once per enabled bit in the frames that carry Sa bits, and stays low at all other times. When alignment is lost the outputs go quiet. A new enable pattern written through the register port takes effect only at the next frame boundary.

Top module: `e1_sa_extract`

## Requirements
- R1: After reset, oh_clk, oh_data and cfg_rdata are all 0.
- R2: A write with cfg_we high stores cfg_wdata into the enable register, and cfg_rdata shows it from the next cycle. Bit 0 selects Sa4, bit 1 Sa5, bit 2 Sa6, bit 3 Sa7 and bit 4 Sa8.
- R3: In each frame that carries Sa bits, oh_clk gives exactly one pulse per enabled Sa bit, and no pulse for a disabled one.
- R4: The pulses carry the Sa bits in the order Sa4, Sa5, Sa6, Sa7, Sa8. Sa4 is frame bit 3, counting the bit under the frame marker as bit 0, and Sa8 is frame bit 7.
- R5: Frame parity is kept from the markers. A frame flagged by the multiframe marker is even, and parity then alternates frame by frame. Even frames produce no oh_clk pulse.
- R6: oh_data takes its new value one line clock before the rising edge of oh_clk, and holds that value while oh_clk is high.
- R7: Each oh_clk pulse is high for exactly one line clock.
- R8: While align_ok is low, oh_clk and oh_data are 0 from the next cycle on. Extraction resumes only in a frame whose frame-marker cycle sees align_ok high.
- R9: A write to the enable register changes extraction only from the next frame marker on. This holds even when the write lands before or during the current frame's Sa bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive line clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Recovered serial data |
| frame_mark | input | 1 | High with bit 0 of each frame |
| mframe_mark | input | 1 | High with frame_mark on frame 0 of a multiframe |
| align_ok | input | 1 | Frame alignment declared |
| cfg_we | input | 1 | Enable register write strobe |
| cfg_wdata | input | SA_NUM | Enable pattern, bit 0 = Sa4 |
| cfg_rdata | output | SA_NUM | Enable register contents |
| oh_clk | output | 1 | Gated strobe, one pulse per extracted bit |
| oh_data | output | 1 | Extracted Sa bit |

## Verification
All 32 enable patterns are swept, each over an even frame and the following odd frame. Frame contents are derived arithmetically from the frame number, so a bit delivered from the wrong position, in the wrong order or from the wrong frame shows up as a value mismatch, not only as a count mismatch. An all-ones frame followed by a frame that drops alignment tells output forcing apart from plain holding. Enable writes placed before and during the Sa window show whether reconfiguration is deferred. A multiframe marker placed on a frame that would otherwise be odd shows whether parity is taken from the markers.

// File: rtl/e1_sa_extract.sv
module e1_sa_extract #(
  parameter int FRAME_BITS = 256,
  parameter int SA_FIRST   = 3,
  parameter int SA_NUM     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  input  logic              frame_mark,
  input  logic              mframe_mark,
  input  logic              align_ok,
  input  logic              cfg_we,
  input  logic [SA_NUM-1:0] cfg_wdata,
  output logic [SA_NUM-1:0] cfg_rdata,
  output logic              oh_clk,
  output logic              oh_data
);

  localparam int CW       = $clog2(FRAME_BITS);
  localparam int OUT_BASE = SA_FIRST + SA_NUM;

  logic [CW-1:0]     bit_cnt;
  logic [CW-1:0]     idx;
  logic [SA_NUM-1:0] en_reg, en_act, sa_buf;
  logic              odd_frame, locked, live;

  assign idx       = frame_mark ? '0 : bit_cnt;
  assign live      = odd_frame & locked & align_ok;
  assign cfg_rdata = en_reg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      en_reg    <= '0;
      en_act    <= '0;
      sa_buf    <= '0;
      odd_frame <= 1'b0;
      locked    <= 1'b0;
      oh_clk    <= 1'b0;
      oh_data   <= 1'b0;
    end else begin
      if (cfg_we) en_reg <= cfg_wdata;

      if (frame_mark) bit_cnt <= CW'(1);
      else if (bit_cnt == CW'(FRAME_BITS - 1)) bit_cnt <= '0;
      else bit_cnt <= bit_cnt + CW'(1);

      if (frame_mark) begin
        odd_frame <= !mframe_mark && !odd_frame;
        en_act    <= en_reg;
        locked    <= align_ok;
      end else if (!align_ok) begin
        locked <= 1'b0;
      end

      for (int i = 0; i < SA_NUM; i++)
        if (idx == CW'(SA_FIRST + i)) sa_buf[i] <= rx_bit;

      oh_clk <= 1'b0;
      if (!align_ok) begin
        oh_data <= 1'b0;
      end else if (live) begin
        for (int i = 0; i < SA_NUM; i++) begin
          if (en_act[i] && idx == CW'(OUT_BASE + 2*i))     oh_data <= sa_buf[i];
          if (en_act[i] && idx == CW'(OUT_BASE + 2*i + 1)) oh_clk  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/e1_sa_extract_chk.sv
module e1_sa_extract_chk #(
  parameter int SA_NUM = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_mark,
  input logic              mframe_mark,
  input logic              align_ok,
  input logic              cfg_we,
  input logic [SA_NUM-1:0] cfg_wdata,
  input logic [SA_NUM-1:0] cfg_rdata,
  input logic              oh_clk,
  input logic              oh_data
);

  logic       par;
  logic [7:0] pulses;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par    <= 1'b0;
      pulses <= '0;
    end else begin
      if (frame_mark) par <= !mframe_mark && !par;
      if (frame_mark) pulses <= '0;
      else if (oh_clk) pulses <= pulses + 8'd1;
    end
  end

  AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == $past(cfg_wdata))); // R2
  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pulses <= 8'(SA_NUM)); // R3
  AST_EVEN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    oh_clk |-> par); // R5
  AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oh_clk) |-> $stable(oh_data)); // R6
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    oh_clk |=> !oh_clk); // R7
  AST_QUIET_UNALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    !align_ok |=> (!oh_clk && !oh_data)); // R8

endmodule

bind e1_sa_extract e1_sa_extract_chk #(.SA_NUM(SA_NUM)) u_chk (.*);

// File: tb/tb_e1_sa_extract.sv
module tb_e1_sa_extract;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_bit = 1'b0, frame_mark = 1'b0, mframe_mark = 1'b0, align_ok = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic [4:0] cfg_rdata;
  logic       oh_clk, oh_data;

  int checks = 0, errors = 0;
  int fno = 0;
  logic par = 1'b0;
  logic [4:0] en_shadow = '0;
  logic cap [8];
  int cap_n = 0;
  logic prev_clk = 1'b0, prev_data = 1'b0, bad8 = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  e1_sa_extract dut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .frame_mark(frame_mark),
    .mframe_mark(mframe_mark), .align_ok(align_ok), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .oh_clk(oh_clk), .oh_data(oh_data)
  );

  function automatic logic pat(int f, int i);
    int v = f * 37 + i * 11 + (f >> 2) * i;
    return v[2] ^ v[0] ^ v[4];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (frame %0d)", req, act, exp, fno);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (oh_clk) begin
        chk(!prev_clk, "R7", 1, 0);
        chk(oh_data === prev_data, "R6", int'(oh_data), int'(prev_data));
        if (cap_n < 8) cap[cap_n] = oh_data;
        cap_n++;
      end
      if (!align_ok && (oh_clk || oh_data)) bad8 = 1'b1;
      prev_clk = oh_clk;
      prev_data = oh_data;
    end
  end

  task automatic run_frame(bit mf, int wr_at, logic [4:0] wv, int drop_at, bit ones);
    logic [4:0] en_eff = en_shadow;
    logic exp [5];
    int n = 0;
    par = mf ? 1'b0 : ~par;
    cap_n = 0;
    bad8 = 1'b0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      frame_mark  = (k == 0);
      mframe_mark = (k == 0) && mf;
      if (k == 0) align_ok = 1'b1;
      if (k == drop_at) align_ok = 1'b0;
      rx_bit = ones ? 1'b1 : pat(fno, k);
      cfg_we = (k == wr_at);
      if (k == wr_at) begin
        cfg_wdata = wv;
        en_shadow = wv;
      end
    end
    if (par && drop_at < 0)
      for (int i = 0; i < 5; i++)
        if (en_eff[i]) begin
          exp[n] = ones ? 1'b1 : pat(fno, 3 + i);
          n++;
        end
    if (!par) chk(cap_n == 0, "R5", cap_n, 0);
    else if (drop_at >= 0) chk(cap_n == 0, "R8", cap_n, 0);
    else chk(cap_n == n, "R3", cap_n, n);
    if (cap_n == n)
      for (int i = 0; i < n; i++) chk(cap[i] === exp[i], "R4", int'(cap[i]), int'(exp[i]));
    if (drop_at >= 0) begin
      chk(!bad8, "R8", int'(bad8), 0);
      chk(oh_data === 1'b0, "R8", int'(oh_data), 0);
    end
    chk(cfg_rdata === en_shadow, "R2", int'(cfg_rdata), int'(en_shadow));
    fno++;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(oh_clk === 1'b0, "R1", int'(oh_clk), 0);
    chk(oh_data === 1'b0, "R1", int'(oh_data), 0);
    chk(cfg_rdata === 5'd0, "R1", int'(cfg_rdata), 0);
    rst_n = 1'b1;
    // exhaustive enable sweep over even/odd frame pairs
    for (int e = 0; e < 32; e++) begin
      run_frame(fno % 16 == 0, 100, 5'(e), -1, 1'b0);
      run_frame(1'b0, -1, 5'd0, -1, 1'b0);
    end
    // R8: all-ones odd frame leaves oh_data high, then alignment drops
    run_frame(fno % 16 == 0, 100, 5'h1f, -1, 1'b0);
    run_frame(1'b0, -1, 5'd0, -1, 1'b1);
    run_frame(1'b0, -1, 5'd0, -1, 1'b0);
    run_frame(1'b0, -1, 5'd0, 2, 1'b0);
    run_frame(1'b0, -1, 5'd0, -1, 1'b0);
    run_frame(1'b0, -1, 5'd0, -1, 1'b0);
    // R9: writes before and inside the Sa window are deferred
    run_frame(1'b0, -1, 5'd0, -1, 1'b0);
    run_frame(1'b0, 2, 5'b00101, -1, 1'b0);
    run_frame(1'b0, -1, 5'd0, -1, 1'b0);
    run_frame(1'b0, 12, 5'b11000, -1, 1'b0);
    run_frame(1'b0, -1, 5'd0, -1, 1'b0);
    run_frame(1'b0, -1, 5'd0, -1, 1'b0);
    // R5: multiframe marker forces an even frame out of turn
    run_frame(1'b0, -1, 5'd0, -1, 1'b0);
    run_frame(1'b1, -1, 5'd0, -1, 1'b0);
    run_frame(1'b0, -1, 5'd0, -1, 1'b0);
    @(negedge clk);
    frame_mark = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule